// File: doc/BRIEF.md
# Single-Clock FIFO with Near-Full Margin Flag

This block is a first-in first-out buffer for one clock domain. A producer offers a word with a push strobe and a consumer takes one with a pop strobe. The two strobes are independent, so a word can enter and another can leave in the same cycle. Storage is a register array with one write port and one read port. The array is read without a clock, so the oldest word is always on the read data output. A consumer state machine can act on the word in the same cycle that the not-empty flag is high.

Full and empty are registered flags. Full is set by the push that fills the last free entry and is cleared only by an accepted pop. Empty is set by the pop that takes the last word and is cleared only by an accepted push. A separate level counter starts at the margin value (seven by default) and is compared with the depth. It drives a near-full flag that warns the producer several entries before the buffer fills.

Inverted copies of both flags are provided so that instances can be chained with no glue. The upstream not-empty drives the downstream push, and the downstream not-full drives the upstream pop.

Top module: `sync_fifo_flags`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released: empty=1, not_empty=0, full=0, not_full=1, near_full=0.
- R2: A push with full=0 stores wr_data at that clock edge. Words leave in the order they were accepted.
- R3: Whenever not_empty=1, rd_data carries the oldest stored word. After a push into an empty buffer, that word is on rd_data from the first cycle in which not_empty is high.
- R4: full rises after the clock edge that accepts the DEPTH-th unpopped word. It stays high until a pop is accepted.
- R5: empty rises after the clock edge that takes the last word. It stays high until a push is accepted.
- R6: A push while full=1 is ignored. The flags, the head word and the stored contents are unchanged.
- R7: A pop while empty=1 is ignored. empty stays high, and the next push is stored and read back correctly.
- R8: A push and a pop in the same cycle, with the buffer neither full nor empty, leave the occupancy and all flags unchanged and keep the word order.
- R9: near_full is high exactly when the occupancy is at least DEPTH-MARGIN. With DEPTH=16 and MARGIN=7, that is 9 or more words.
- R10: not_full is always the inverse of full, and not_empty is always the inverse of empty.
- R11: A push and a pop together while full perform only the pop. A push and a pop together while empty perform only the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push | input | 1 | Write strobe |
| wr_data | input | DATA_W | Word to store |
| pop | input | 1 | Read strobe |
| rd_data | output | DATA_W | Oldest stored word, valid when not_empty is high |
| full | output | 1 | No free entry |
| not_full | output | 1 | Inverse of full |
| empty | output | 1 | No stored word |
| not_empty | output | 1 | Inverse of empty |
| near_full | output | 1 | Occupancy has reached DEPTH-MARGIN |

## Verification
A wrong pointer shows at rd_data within one cycle as a word out of order or a repeated word. The bench therefore compares the head against the expected sequence after every accepted operation. A wrong full or empty flag either drops a push or a pop, which shows later as a missing word, or accepts an extra one, which shows as a duplicate or a stale word. Draining the buffer completely exposes both cases. A level counter that has drifted shows as near_full changing one or more entries away from the threshold, so the bench checks near_full after each single step across the threshold in both directions.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic [1:0] {
    XF_IDLE = 2'b00,
    XF_POP  = 2'b01,
    XF_PUSH = 2'b10,
    XF_BOTH = 2'b11
  } xfer_e;

  function automatic int unsigned level_width(int unsigned depth, int unsigned margin);
    return $clog2(depth + margin + 1);
  endfunction
endpackage

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && (waddr == ADDR_W'(g))) begin
        cells[g] <= wdata;
      end
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_ctl.sv
module fifo_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] wptr,
  output logic [ADDR_W-1:0] rptr,
  output logic              full,
  output logic              empty
);
  import fifo_pkg::*;

  logic [ADDR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic              full_q, full_d, empty_q, empty_d;
  xfer_e             xf;

  assign wr_ok = push & ~full_q;
  assign rd_ok = pop & ~empty_q;
  assign xf    = xfer_e'({wr_ok, rd_ok});

  always_comb begin
    wptr_d  = wptr_q;
    rptr_d  = rptr_q;
    full_d  = full_q;
    empty_d = empty_q;
    unique case (xf)
      XF_PUSH: begin
        wptr_d  = wptr_q + 1'b1;
        empty_d = 1'b0;
        if (wptr_d == rptr_q) full_d = 1'b1;
      end
      XF_POP: begin
        rptr_d = rptr_q + 1'b1;
        full_d = 1'b0;
        if (rptr_d == wptr_q) empty_d = 1'b1;
      end
      XF_BOTH: begin
        wptr_d = wptr_q + 1'b1;
        rptr_d = rptr_q + 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (xf != XF_IDLE) begin
      wptr_q  <= wptr_d;
      rptr_q  <= rptr_d;
      full_q  <= full_d;
      empty_q <= empty_d;
    end
  end

  assign wptr  = wptr_q;
  assign rptr  = rptr_q;
  assign full  = full_q;
  assign empty = empty_q;
endmodule

// File: rtl/fifo_margin.sv
module fifo_margin #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned MARGIN = 7,
  localparam int unsigned LVL_W = fifo_pkg::level_width(DEPTH, MARGIN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ok,
  input  logic rd_ok,
  output logic near_full
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             near_q, near_d;
  logic             step_en;

  assign step_en = wr_ok ^ rd_ok;

  always_comb begin
    lvl_d  = lvl_q + LVL_W'(wr_ok) - LVL_W'(rd_ok);
    near_d = (lvl_d >= LVL_W'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= LVL_W'(MARGIN);
      near_q <= 1'b0;
    end else if (step_en) begin
      lvl_q  <= lvl_d;
      near_q <= near_d;
    end
  end

  assign near_full = near_q;
endmodule

// File: rtl/sync_fifo_flags.sv
module sync_fifo_flags #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned MARGIN = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              not_full,
  output logic              empty,
  output logic              not_empty,
  output logic              near_full
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);

  logic              wr_ok, rd_ok;
  logic [ADDR_W-1:0] wptr, rptr;

  fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .wr_ok(wr_ok), .rd_ok(rd_ok), .wptr(wptr), .rptr(rptr),
    .full(full), .empty(empty)
  );

  fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en(wr_ok), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(rd_data)
  );

  fifo_margin #(.DEPTH(DEPTH), .MARGIN(MARGIN)) u_margin (
    .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .near_full(near_full)
  );

  assign not_full  = ~full;
  assign not_empty = ~empty;
endmodule

// File: rtl/sync_fifo_flags_chk.sv
module sync_fifo_flags_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push,
  input logic [DATA_W-1:0] wr_data,
  input logic              pop,
  input logic [DATA_W-1:0] rd_data,
  input logic              full,
  input logic              not_full,
  input logic              empty,
  input logic              not_empty,
  input logic              near_full
);
  // R10
  flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (not_full == !full) && (not_empty == !empty));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full);

  // R5
  empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push |=> empty);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && !pop |=> full && $stable(rd_data));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop && !push |=> empty);

  // R3
  head_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty && push |=> !empty && (rd_data == $past(wr_data)));

  // R8
  both_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop && !full && !empty |=> $stable(full) && $stable(empty) && $stable(near_full));

  // R9
  near_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> near_full);

  // R11
  full_pop_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full && push && pop |=> !full);
endmodule

bind sync_fifo_flags sync_fifo_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_sync_fifo_flags.sv
module sim_sync_fifo_flags;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned MARGIN = 7;
  localparam int unsigned NEAR_AT = DEPTH - MARGIN;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push = 1'b0;
  logic          pop = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          full, not_full, empty, not_empty, near_full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sync_fifo_flags #(.DATA_W(DW), .DEPTH(DEPTH), .MARGIN(MARGIN)) u0 (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_data(wr_data), .pop(pop),
    .rd_data(rd_data), .full(full), .not_full(not_full), .empty(empty),
    .not_empty(not_empty), .near_full(near_full)
  );

  typedef struct packed {
    logic          psh;
    logic          pp;
    logic [DW-1:0] d;
    logic          x_empty;
    logic          x_near;
    logic [DW-1:0] x_head;
  } vec_t;

  // Walk from empty: R2, R3, R5, R7, R8, R11
  localparam vec_t VECS [8] = '{
    '{1'b1, 1'b0, 8'hA1, 1'b0, 1'b0, 8'hA1},
    '{1'b1, 1'b0, 8'hB2, 1'b0, 1'b0, 8'hA1},
    '{1'b1, 1'b1, 8'hC3, 1'b0, 1'b0, 8'hB2},
    '{1'b0, 1'b1, 8'h00, 1'b0, 1'b0, 8'hC3},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00},
    '{1'b1, 1'b1, 8'hD4, 1'b0, 1'b0, 8'hD4},
    '{1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic p, input logic q, input logic [DW-1:0] d);
    @(negedge clk);
    push = p; pop = q; wr_data = d;
    @(posedge clk);
    #2;
    push = 1'b0; pop = 1'b0;
  endtask

  task automatic flags_pair();
    chk("R10 not_full", {31'd0, not_full}, {31'd0, ~full});
    chk("R10 not_empty", {31'd0, not_empty}, {31'd0, ~empty});
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 during and just after reset
    repeat (2) @(posedge clk);
    #2;
    chk("R1 empty", {31'd0, empty}, 32'd1);
    chk("R1 full", {31'd0, full}, 32'd0);
    chk("R1 near", {31'd0, near_full}, 32'd0);
    flags_pair();
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    chk("R1 empty after release", {31'd0, empty}, 32'd1);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      step(VECS[i].psh, VECS[i].pp, VECS[i].d);
      chk("R5/R7 empty", {31'd0, empty}, {31'd0, VECS[i].x_empty});
      chk("R9 near", {31'd0, near_full}, {31'd0, VECS[i].x_near});
      chk("R4 full", {31'd0, full}, 32'd0);
      flags_pair();
      if (!VECS[i].x_empty) chk("R2/R3/R8/R11 head", {24'd0, rd_data}, {24'd0, VECS[i].x_head});
    end

    // Fill to full: R4, R9
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, DW'(8'h10 + i));
      chk("R9 near on fill", {31'd0, near_full}, {31'd0, (i + 1) >= NEAR_AT});
      chk("R4 full on fill", {31'd0, full}, {31'd0, i == DEPTH - 1});
      chk("R3 head on fill", {24'd0, rd_data}, 32'h10);
    end
    // R6 push while full ignored
    step(1'b1, 1'b0, 8'hEE);
    chk("R6 full kept", {31'd0, full}, 32'd1);
    chk("R6 head kept", {24'd0, rd_data}, 32'h10);
    flags_pair();
    // R11 push+pop while full: pop only
    step(1'b1, 1'b1, 8'hEF);
    chk("R11 full cleared", {31'd0, full}, 32'd0);
    chk("R11 head advanced", {24'd0, rd_data}, 32'h11);
    chk("R9 near at 15", {31'd0, near_full}, 32'd1);
    step(1'b1, 1'b0, 8'h30);
    chk("R4 full again", {31'd0, full}, 32'd1);
    // Drain: order and empty
    for (int i = 0; i < DEPTH; i++) begin
      logic [DW-1:0] exp_w;
      int left;
      exp_w = (i < DEPTH - 1) ? DW'(8'h11 + i) : 8'h30;
      chk("R2/R6 drain order", {24'd0, rd_data}, {24'd0, exp_w});
      step(1'b0, 1'b1, 8'h00);
      left = DEPTH - 1 - i;
      chk("R9 near on drain", {31'd0, near_full}, {31'd0, left >= NEAR_AT});
      chk("R5 empty on drain", {31'd0, empty}, {31'd0, left == 0});
      chk("R4 full clear on drain", {31'd0, full}, 32'd0);
    end
    // R7 after extra pops, next push is clean
    step(1'b0, 1'b1, 8'h00);
    step(1'b1, 1'b0, 8'h5A);
    chk("R7 push after underflow", {24'd0, rd_data}, 32'h5A);
    chk("R7 not_empty", {31'd0, not_empty}, 32'd1);

    // R1 reset mid-operation
    step(1'b1, 1'b0, 8'h66);
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R1 empty mid reset", {31'd0, empty}, 32'd1);
    chk("R1 near mid reset", {31'd0, near_full}, 32'd0);
    flags_pair();
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h77);
    chk("R1 head after reset", {24'd0, rd_data}, 32'h77);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule